// File: doc/BRIEF.md
# Snooping MESI Coherence Cluster

This block holds a small group of private caches that share one snooped bus and keeps them coherent with a four-state protocol: Modified, Exclusive, Shared, Invalid. Each cache tracks a fixed set of lines. Every line has a two-bit state and one data word. No tags or replacement are modelled: line index N always stands for memory word N. A cache accepts read, write and drop requests from its processor. A request that can finish locally is acknowledged in the same cycle. A request that needs the bus goes through a fixed-priority arbiter. It then issues a read, a read-for-ownership or a dataless upgrade. Every other cache snoops that transaction in the same cycle.

The caches that snoop the transaction report whether they hold the line. When the transaction carries data, the lowest-numbered cache with a valid copy supplies it. Memory supplies the data only when no cache holds the line. A dirty line that answers a snooped read is also written back to memory in the same cycle. Memory sits outside the block: the bus address selects a word on a combinational read port, and write-backs leave through a write port. All state changes take effect at the clock edge that ends the serving cycle.

Top module: `mesi_snoop_cluster`

## Requirements
- R1: After reset every line of every cache is Invalid (code 0), no request is acknowledged without being driven, and the bus is idle (bus_valid low, bus_cmd 0). State codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified. Bus command codes are 0 none, 1 read, 2 read-for-ownership, 3 upgrade. Request op codes are 1 write and 2 drop; every other op code is a read.
- R2: A read to an Invalid line issues command 1 and returns the bus data in the acknowledge cycle. If a peer holds a valid copy, the line fills to Shared and every peer copy ends in Shared. Otherwise the line fills to Exclusive.
- R3: A write to an Invalid line issues command 2. The requester ends in Modified, holding the written word, and every peer copy becomes Invalid.
- R4: A write to a Shared line issues command 3. No cache supplies data and memory is not written. The requester ends in Modified and every peer copy becomes Invalid.
- R5: A write to an Exclusive or Modified line, and a read to any valid line, are acknowledged in the cycle they are presented and issue no bus command. A write leaves the line Modified with the new word. A read returns the stored word and leaves the state unchanged.
- R6: When a Modified line is snooped by command 1, its word is placed on mem_wr_data with mem_wr_en high in that cycle, and the line moves to Shared.
- R7: For commands 1 and 2, if any peer holds a valid copy, the data comes from the lowest-numbered holder: bus_from_cache is high and bus_src_id gives that holder. If no peer holds a copy, the data comes from memory and bus_from_cache is low.
- R8: When a Modified line is snooped by command 2, it supplies its word to the requester and becomes Invalid, and memory is not written.
- R9: A drop of a Shared or Exclusive line makes it Invalid with no bus command. A drop of a Modified line is acknowledged and has no effect.
- R10: When several caches need the bus, only the lowest-numbered one is granted. bus_owner names it. The other requesters are not acknowledged and keep waiting.
- R11: A local-only request (R5, R9) stalls without acknowledge in any cycle in which a peer's bus transaction targets the same line. It proceeds in the same cycle when the peer targets a different line.
- R12: For one line and caches 0, 1 and 2, the sequence read 0, write 0, read 2, write 2, read 0, read 2, read 1 yields the state triples E/I/I, M/I/I, S/I/S, I/I/M, S/I/S, S/I/S, S/S/S. It yields the bus commands 1, 0, 1, 3, 1, 0, 1.
- R13: At every clock edge, a line that is Modified or Exclusive in one cache is Invalid in every other cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NCACHE | Request present, one bit per cache, held until acknowledged |
| req_op | input | 2*NCACHE | Request op per cache: 1 write, 2 drop, else read |
| req_addr | input | NCACHE*ADDR_W | Line index per cache |
| req_wdata | input | NCACHE*DATA_W | Write word per cache |
| resp_valid | output | NCACHE | Request served in this cycle |
| resp_rdata | output | NCACHE*DATA_W | Read word per cache, valid with resp_valid |
| line_state | output | NCACHE*NLINES*2 | State codes; cache c, line l at bits (c*NLINES+l)*2 |
| bus_valid | output | 1 | A bus transaction is under way |
| bus_cmd | output | 2 | Current bus command code |
| bus_owner | output | ID_W | Cache granted the bus |
| bus_addr | output | ADDR_W | Line addressed on the bus; also the memory read/write address |
| bus_from_cache | output | 1 | Data supplied cache-to-cache |
| bus_src_id | output | ID_W | Supplying cache when bus_from_cache is high |
| mem_rd_data | input | DATA_W | Memory word at bus_addr |
| mem_wr_en | output | 1 | Write-back of a dirty line this cycle |
| mem_wr_data | output | DATA_W | Write-back word |

## Verification
Two functions can land on one line in one cycle. The first is a local hit or drop, which touches only that cache's state. The second is a peer's bus transaction, which snoops the same line and may invalidate or demote it. The bench provokes this by presenting, at the same clock edge, a read hit in one cache and an upgrade for the same line from another cache. It judges the outcome from the acknowledge vector: only the upgrade is served. In the next cycle the stalled reader misses and takes the new word cache-to-cache with a write-back. A second case drives a hit and a bus transaction on different lines, and both must be acknowledged together.

// File: rtl/mesi_pkg.sv
// Shared encodings for the snooping coherence cluster.
// Assumes two-bit state and command fields throughout.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPGR = 2'd3
    } bus_cmd_e;

    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_DROP  = 2'd2;
endpackage

// File: rtl/mesi_prio_arb.sv
// Fixed-priority bus arbiter: the lowest-numbered requester wins.
// Assumes requests are combinational and stable within a cycle.
module mesi_prio_arb #(
    parameter int N    = 3,
    parameter int ID_W = 2
) (
    input  logic [N-1:0]    req,
    output logic [N-1:0]    grant,
    output logic            any,
    output logic [ID_W-1:0] idx
);
    // Scan from the top so the lowest index overwrites the choice.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = ID_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/mesi_snoop_resolve.sv
// Combines snoop answers: shared indication, data provider choice,
// bus data mux and dirty write-back strobe.
// Assumes hold/dirty are already gated to exclude the bus owner.
module mesi_snoop_resolve
    import mesi_pkg::*;
#(
    parameter int N      = 3,
    parameter int DATA_W = 8,
    parameter int ID_W   = 2
) (
    input  logic              bus_active,
    input  logic [1:0]        cmd,
    input  logic [N-1:0]      hold,
    input  logic [N-1:0]      dirty,
    input  logic [N*DATA_W-1:0] data_flat,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              shared,
    output logic              from_cache,
    output logic [ID_W-1:0]   src_id,
    output logic [DATA_W-1:0] data,
    output logic              wb_en
);
    int sidx;

    // Pick the lowest-numbered holder as the supplier.
    always_comb begin
        sidx = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hold[i]) sidx = i;
        end
    end

    // Decide the data source and whether memory must absorb a dirty line.
    always_comb begin
        shared     = |hold;
        from_cache = bus_active && (cmd == CMD_RD || cmd == CMD_RDX) && (|hold);
        src_id     = ID_W'(sidx);
        data       = from_cache ? data_flat[sidx*DATA_W +: DATA_W] : mem_rd_data;
        wb_en      = from_cache && (cmd == CMD_RD) && dirty[sidx];
    end
endmodule

// File: rtl/mesi_cache_ctrl.sv
// Per-cache coherence controller: holds state and one word per line,
// decides the bus command for a request, answers snoops and applies
// both local and snooped transitions at the clock edge.
// Assumes the request is held until acknowledged and that a snoop is
// never addressed by this cache's own transaction.
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                resp_valid,
    output logic [DATA_W-1:0]   resp_rdata,
    output logic                need_bus,
    output logic [1:0]          need_cmd,
    input  logic                grant,
    input  logic                snoop_valid,
    input  logic [1:0]          snoop_cmd,
    input  logic [ADDR_W-1:0]   snoop_addr,
    output logic                snp_hold,
    output logic                snp_dirty,
    output logic [DATA_W-1:0]   snp_data,
    input  logic                bus_shared,
    input  logic [DATA_W-1:0]   bus_data,
    output logic [2*NLINES-1:0] state_flat
);
    mesi_st_e          st_q  [NLINES];
    mesi_st_e          st_d  [NLINES];
    logic [DATA_W-1:0] dat_q [NLINES];
    logic [DATA_W-1:0] dat_d [NLINES];

    mesi_st_e cur_st;
    logic     is_wr, is_drop, is_rd, snoop_same, local_go;

    // Classify the request and choose the bus command it needs.
    always_comb begin
        cur_st     = st_q[req_addr];
        is_wr      = (req_op == OP_WRITE);
        is_drop    = (req_op == OP_DROP);
        is_rd      = !is_wr && !is_drop;
        need_bus   = req_valid && ((is_rd && cur_st == ST_I) ||
                                   (is_wr && (cur_st == ST_I || cur_st == ST_S)));
        if (!need_bus)          need_cmd = CMD_NONE;
        else if (is_rd)         need_cmd = CMD_RD;
        else if (cur_st == ST_I) need_cmd = CMD_RDX;
        else                    need_cmd = CMD_UPGR;
        snoop_same = snoop_valid && (snoop_addr == req_addr);
        local_go   = req_valid && !need_bus && !snoop_same;
        resp_valid = local_go || (need_bus && grant);
        resp_rdata = need_bus ? bus_data : dat_q[req_addr];
    end

    // Answer a peer's transaction from the addressed line.
    always_comb begin
        snp_hold  = snoop_valid && (st_q[snoop_addr] != ST_I);
        snp_dirty = snoop_valid && (st_q[snoop_addr] == ST_M);
        snp_data  = dat_q[snoop_addr];
    end

    // Next state: snooped effects first, then this cache's own action.
    always_comb begin
        st_d  = st_q;
        dat_d = dat_q;
        if (snoop_valid) begin
            case (snoop_cmd)
                CMD_RD:   if (st_q[snoop_addr] != ST_I) st_d[snoop_addr] = ST_S;
                CMD_RDX,
                CMD_UPGR: st_d[snoop_addr] = ST_I;
                default:  ;
            endcase
        end
        if (need_bus && grant) begin
            if (need_cmd == CMD_RD) begin
                st_d[req_addr]  = bus_shared ? ST_S : ST_E;
                dat_d[req_addr] = bus_data;
            end else begin
                st_d[req_addr]  = ST_M;
                dat_d[req_addr] = req_wdata;
            end
        end else if (local_go) begin
            if (is_wr) begin
                st_d[req_addr]  = ST_M;
                dat_d[req_addr] = req_wdata;
            end else if (is_drop && cur_st != ST_M) begin
                st_d[req_addr]  = ST_I;
            end
        end
    end

    // State and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= ST_I;
                dat_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            dat_q <= dat_d;
        end
    end

    // Expose line states as a flat vector.
    for (genvar l = 0; l < NLINES; l++) begin : g_state
        assign state_flat[2*l +: 2] = st_q[l];
    end
endmodule

// File: rtl/mesi_snoop_cluster.sv
// Cluster of snooping caches on one bus with a fixed-priority arbiter.
// Assumes one bus transaction per cycle, completed in that cycle, and a
// combinational memory read port addressed by bus_addr.
module mesi_snoop_cluster
    import mesi_pkg::*;
#(
    parameter int  NCACHE = 3,
    parameter int  NLINES = 4,
    parameter int  DATA_W = 8,
    localparam int ADDR_W = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int ID_W   = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCACHE-1:0]            req_valid,
    input  logic [2*NCACHE-1:0]          req_op,
    input  logic [NCACHE*ADDR_W-1:0]     req_addr,
    input  logic [NCACHE*DATA_W-1:0]     req_wdata,
    output logic [NCACHE-1:0]            resp_valid,
    output logic [NCACHE*DATA_W-1:0]     resp_rdata,
    output logic [NCACHE*NLINES*2-1:0]   line_state,
    output logic                         bus_valid,
    output logic [1:0]                   bus_cmd,
    output logic [ID_W-1:0]              bus_owner,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic                         bus_from_cache,
    output logic [ID_W-1:0]              bus_src_id,
    input  logic [DATA_W-1:0]            mem_rd_data,
    output logic                         mem_wr_en,
    output logic [DATA_W-1:0]            mem_wr_data
);
    logic [NCACHE-1:0]        need_w, grant_w, hold_w, dirty_w;
    logic [2*NCACHE-1:0]      need_cmd_w;
    logic [NCACHE*DATA_W-1:0] snp_data_w;
    logic                     bus_any, shared_w;
    logic [DATA_W-1:0]        bus_data_w;

    mesi_prio_arb #(.N(NCACHE), .ID_W(ID_W)) u_arb (
        .req   (need_w),
        .grant (grant_w),
        .any   (bus_any),
        .idx   (bus_owner)
    );

    // Place the granted cache's command and line on the bus.
    always_comb begin
        bus_valid = bus_any;
        bus_cmd   = bus_any ? need_cmd_w[int'(bus_owner)*2 +: 2] : CMD_NONE;
        bus_addr  = bus_any ? req_addr[int'(bus_owner)*ADDR_W +: ADDR_W] : '0;
    end

    for (genvar c = 0; c < NCACHE; c++) begin : g_cache
        mesi_cache_ctrl #(.NLINES(NLINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid   (req_valid[c]),
            .req_op      (req_op[2*c +: 2]),
            .req_addr    (req_addr[c*ADDR_W +: ADDR_W]),
            .req_wdata   (req_wdata[c*DATA_W +: DATA_W]),
            .resp_valid  (resp_valid[c]),
            .resp_rdata  (resp_rdata[c*DATA_W +: DATA_W]),
            .need_bus    (need_w[c]),
            .need_cmd    (need_cmd_w[2*c +: 2]),
            .grant       (grant_w[c]),
            .snoop_valid (bus_any && !grant_w[c]),
            .snoop_cmd   (bus_cmd),
            .snoop_addr  (bus_addr),
            .snp_hold    (hold_w[c]),
            .snp_dirty   (dirty_w[c]),
            .snp_data    (snp_data_w[c*DATA_W +: DATA_W]),
            .bus_shared  (shared_w),
            .bus_data    (bus_data_w),
            .state_flat  (line_state[c*2*NLINES +: 2*NLINES])
        );
    end

    mesi_snoop_resolve #(.N(NCACHE), .DATA_W(DATA_W), .ID_W(ID_W)) u_res (
        .bus_active  (bus_any),
        .cmd         (bus_cmd),
        .hold        (hold_w),
        .dirty       (dirty_w),
        .data_flat   (snp_data_w),
        .mem_rd_data (mem_rd_data),
        .shared      (shared_w),
        .from_cache  (bus_from_cache),
        .src_id      (bus_src_id),
        .data        (bus_data_w),
        .wb_en       (mem_wr_en)
    );

    assign mem_wr_data = bus_data_w;
endmodule

// File: rtl/mesi_snoop_checker.sv
// Protocol checker bound into the cluster: single-owner invariant,
// post-transaction states, write-back and arbitration rules.
// Assumes the line_state layout of the cluster.
module mesi_snoop_checker #(
    parameter int NCACHE = 3,
    parameter int NLINES = 4,
    parameter int ADDR_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCACHE*NLINES*2-1:0] line_state,
    input logic                       bus_valid,
    input logic [1:0]                 bus_cmd,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_from_cache,
    input logic                       mem_wr_en,
    input logic [NCACHE-1:0]          grant,
    input logic [NCACHE-1:0]          need
);
    for (genvar l = 0; l < NLINES; l++) begin : g_line
        logic [NCACHE-1:0] vld;
        logic              any_me, any_m;

        // Summarise one line across all caches.
        always_comb begin
            any_me = 1'b0;
            any_m  = 1'b0;
            for (int c = 0; c < NCACHE; c++) begin
                vld[c] = line_state[(c*NLINES+l)*2 +: 2] != 2'd0;
                if (line_state[(c*NLINES+l)*2 +: 2] == 2'd3) any_m = 1'b1;
                if (line_state[(c*NLINES+l)*2 +: 2] >= 2'd2) any_me = 1'b1;
            end
        end

        assert_single_owner_R13: assert property (@(posedge clk) disable iff (!rst_n)
            any_me |-> ($countones(vld) == 1));

        assert_write_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && (bus_cmd == 2'd2 || bus_cmd == 2'd3) && bus_addr == ADDR_W'(l))
            |=> (any_m && $countones(vld) == 1));

        assert_read_shares_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_cmd == 2'd1 && bus_from_cache && bus_addr == ADDR_W'(l))
            |=> (!any_me && $countones(vld) >= 2));

        assert_read_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_cmd == 2'd1 && !bus_from_cache && bus_addr == ADDR_W'(l))
            |=> (any_me && !any_m && $countones(vld) == 1));
    end

    assert_flush_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (bus_valid && bus_cmd == 2'd1 && bus_from_cache));

    assert_upgrade_dataless_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'd3) |-> (!bus_from_cache && !mem_wr_en));

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~need) == '0));

    assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((need & (grant - NCACHE'(1))) == '0));

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (need == '0) |-> (!bus_valid && bus_cmd == 2'd0));
endmodule

bind mesi_snoop_cluster mesi_snoop_checker #(
    .NCACHE (NCACHE),
    .NLINES (NLINES),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_state     (line_state),
    .bus_valid      (bus_valid),
    .bus_cmd        (bus_cmd),
    .bus_addr       (bus_addr),
    .bus_from_cache (bus_from_cache),
    .mem_wr_en      (mem_wr_en),
    .grant          (grant_w),
    .need           (need_w)
);

// File: tb/mesi_snoop_cluster_tb_top.sv
// Self-checking bench: directed trace and corner cases, then seeded
// random single-cache traffic against a protocol model.
module mesi_snoop_cluster_tb_top;
    localparam int NC = 3;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_valid = '0;
    logic [5:0]  req_op = '0;
    logic [5:0]  req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [2:0]  resp_valid;
    logic [23:0] resp_rdata;
    logic [23:0] line_state;
    logic        bus_valid, bus_from_cache, mem_wr_en;
    logic [1:0]  bus_cmd, bus_owner, bus_addr, bus_src_id;
    logic [7:0]  mem_rd_data, mem_wr_data;

    logic [7:0] mem [NL];
    int m_st  [NC][NL];
    int m_dat [NC][NL];
    int m_mem [NL];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mesi_snoop_cluster dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .line_state(line_state), .bus_valid(bus_valid),
        .bus_cmd(bus_cmd), .bus_owner(bus_owner), .bus_addr(bus_addr),
        .bus_from_cache(bus_from_cache), .bus_src_id(bus_src_id),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
    );

    // Memory model: combinational read, write-back at the edge.
    assign mem_rd_data = mem[bus_addr];
    always @(posedge clk) if (mem_wr_en) mem[bus_addr] <= mem_wr_data;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int get_st(input int c, input int l);
        return int'(line_state[(c*NL+l)*2 +: 2]);
    endfunction

    task automatic set_req(input int c, input int op, input int a, input int wd);
        req_valid[c]         = 1'b1;
        req_op[2*c +: 2]     = op[1:0];
        req_addr[2*c +: 2]   = a[1:0];
        req_wdata[8*c +: 8]  = wd[7:0];
    endtask

    // Protocol model for one served request; updates the model state.
    task automatic model_op(input int c, input int op, input int a, input int wd,
                            output int ecmd, output int efrom, output int esrc,
                            output int erd, output int ewb);
        int st = m_st[c][a];
        int h = -1;
        bit is_w = (op == 1);
        bit is_d = (op == 2);
        for (int j = NC - 1; j >= 0; j--) if (j != c && m_st[j][a] != 0) h = j;
        ecmd = 0; efrom = 0; esrc = 0; ewb = 0; erd = m_dat[c][a];
        if (!is_w && !is_d) begin
            if (st == 0) begin
                ecmd = 1;
                if (h >= 0) begin
                    efrom = 1; esrc = h; erd = m_dat[h][a];
                    ewb = (m_st[h][a] == 3);
                    if (ewb) m_mem[a] = erd;
                    for (int j = 0; j < NC; j++) if (m_st[j][a] != 0) m_st[j][a] = 1;
                    m_st[c][a] = 1;
                end else begin
                    erd = m_mem[a];
                    m_st[c][a] = 2;
                end
                m_dat[c][a] = erd;
            end
        end else if (is_w) begin
            if (st == 0) begin
                ecmd = 2;
                if (h >= 0) begin efrom = 1; esrc = h; end
            end else if (st == 1) begin
                ecmd = 3;
            end
            for (int j = 0; j < NC; j++) if (j != c) m_st[j][a] = 0;
            m_st[c][a] = 3;
            m_dat[c][a] = wd & 8'hFF;
        end else begin
            if (st == 1 || st == 2) m_st[c][a] = 0;
        end
    endtask

    // Compare all line states with the model and test the owner invariant.
    task automatic check_states(input string tag);
        int bad = -1;
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++)
                if (bad < 0 && get_st(c, l) != m_st[c][l]) bad = c*NL + l;
        if (bad < 0) check(1'b1, tag, "states", 0, 0);
        else check(1'b0, tag, "state of cache*4+line", get_st(bad/NL, bad%NL),
                   m_st[bad/NL][bad%NL]);
        for (int l = 0; l < NL; l++) begin
            int nv = 0;
            int nme = 0;
            for (int c = 0; c < NC; c++) begin
                if (get_st(c, l) != 0) nv++;
                if (get_st(c, l) >= 2) nme++;
            end
            if (nme > 0) check(nv == 1, "R13", "holders of owned line", nv, 1);
        end
    endtask

    // Serve one request alone; called at a falling edge, returns at one.
    task automatic serve(input int c, input int op, input int a, input int wd,
                         input string tag, output int got_cmd);
        int ecmd, efrom, esrc, erd, ewb;
        model_op(c, op, a, wd, ecmd, efrom, esrc, erd, ewb);
        set_req(c, op, a, wd);
        #2;
        got_cmd = int'(bus_cmd);
        check(resp_valid[c] == 1'b1, tag, "ack", int'(resp_valid), 1 << c);
        check(int'(bus_cmd) == ecmd && bus_valid == (ecmd != 0), tag, "bus cmd",
              int'(bus_cmd), ecmd);
        if (ecmd == 1 || ecmd == 2) begin
            check(int'(bus_from_cache) == efrom, tag, "from cache", int'(bus_from_cache), efrom);
            if (efrom == 1) check(int'(bus_src_id) == esrc, tag, "src id", int'(bus_src_id), esrc);
        end
        if (op != 1 && op != 2)
            check(int'(resp_rdata[8*c +: 8]) == erd, tag, "rdata", int'(resp_rdata[8*c +: 8]), erd);
        check(int'(mem_wr_en) == ewb, tag, "mem write", int'(mem_wr_en), ewb);
        if (ewb == 1) check(int'(mem_wr_data) == erd, tag, "wb data", int'(mem_wr_data), erd);
        @(posedge clk); #1;
        req_valid = '0;
        check_states(tag);
        @(negedge clk);
    endtask

    int tr_cmd [7] = '{1, 0, 1, 3, 1, 0, 1};
    int tr_c   [7] = '{0, 0, 2, 2, 0, 2, 1};
    int tr_op  [7] = '{0, 1, 0, 1, 0, 0, 0};
    int tr_st  [7][3] = '{'{2,0,0}, '{3,0,0}, '{1,0,1}, '{0,0,3},
                          '{1,0,1}, '{1,0,1}, '{1,1,1}};

    initial begin : main
        int cmd, ecmd, efrom, esrc, erd, ewb;
        void'($urandom(32'd24601));
        for (int l = 0; l < NL; l++) begin
            mem[l] = 8'hA0 + 8'(l);
            m_mem[l] = 32'hA0 + l;
            for (int c = 0; c < NC; c++) begin m_st[c][l] = 0; m_dat[c][l] = 0; end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(line_state == '0, "R1", "reset states", int'(line_state), 0);
        check(!bus_valid && bus_cmd == 2'd0 && resp_valid == '0, "R1", "idle bus",
              int'(bus_cmd), 0);

        // R12: the three-cache access trace on line 0
        for (int s = 0; s < 7; s++) begin
            serve(tr_c[s], tr_op[s], 0, 8'h10 + s, "R12", cmd);
            check(cmd == tr_cmd[s], "R12", "trace cmd", cmd, tr_cmd[s]);
            for (int c = 0; c < NC; c++)
                check(get_st(c, 0) == tr_st[s][c], "R12", "trace state", get_st(c, 0), tr_st[s][c]);
        end

        // Directed corner cases on line 1
        serve(0, 0, 1, 0, "R7", cmd);      // memory fill to E
        serve(1, 3, 1, 0, "R2", cmd);      // op 3 reads; peer E -> S
        serve(0, 1, 1, 8'h33, "R4", cmd);  // upgrade from S
        serve(0, 1, 1, 8'h34, "R5", cmd);  // write hit in M
        serve(0, 0, 1, 0, "R5", cmd);      // read hit in M
        serve(1, 1, 1, 8'h41, "R8", cmd);  // RFO takes dirty line, no write-back
        serve(1, 2, 1, 0, "R9", cmd);      // drop of M ignored
        serve(2, 0, 1, 0, "R6", cmd);      // read snoops M: flush
        check(mem[1] == 8'h41, "R6", "memory after flush", int'(mem[1]), 8'h41);
        serve(2, 2, 1, 0, "R9", cmd);      // drop of S
        serve(2, 1, 1, 8'h52, "R3", cmd);  // write miss, peer S supplies

        // R10: two read misses on line 2 in the same cycle
        set_req(1, 0, 2, 0);
        set_req(2, 0, 2, 0);
        #2;
        check(resp_valid == 3'b010, "R10", "ack vector", int'(resp_valid), 3'b010);
        check(bus_owner == 2'd1, "R10", "owner", int'(bus_owner), 1);
        model_op(1, 0, 2, 0, ecmd, efrom, esrc, erd, ewb);
        @(posedge clk); #1 req_valid[1] = 1'b0;
        @(negedge clk); #2;
        check(resp_valid == 3'b100, "R10", "waiter ack", int'(resp_valid), 3'b100);
        model_op(2, 0, 2, 0, ecmd, efrom, esrc, erd, ewb);
        check(bus_from_cache && bus_src_id == 2'd1, "R10", "waiter source", int'(bus_src_id), 1);
        check(int'(resp_rdata[16 +: 8]) == erd, "R10", "waiter rdata", int'(resp_rdata[16 +: 8]), erd);
        @(posedge clk); #1 req_valid = '0;
        check_states("R10");
        @(negedge clk);

        // R11: read hit collides with a peer upgrade on line 3
        serve(0, 0, 3, 0, "R7", cmd);
        serve(1, 0, 3, 0, "R2", cmd);
        set_req(0, 0, 3, 0);
        set_req(1, 1, 3, 8'h5C);
        #2;
        check(resp_valid == 3'b010, "R11", "stall on same line", int'(resp_valid), 3'b010);
        check(bus_cmd == 2'd3, "R11", "upgrade cmd", int'(bus_cmd), 3);
        model_op(1, 1, 3, 8'h5C, ecmd, efrom, esrc, erd, ewb);
        @(posedge clk); #1 req_valid[1] = 1'b0;
        @(negedge clk); #2;
        check(resp_valid == 3'b001 && bus_cmd == 2'd1, "R11", "retry as miss", int'(bus_cmd), 1);
        check(resp_rdata[7:0] == 8'h5C && mem_wr_en, "R11", "retry data", int'(resp_rdata[7:0]), 8'h5C);
        model_op(0, 0, 3, 0, ecmd, efrom, esrc, erd, ewb);
        @(posedge clk); #1 req_valid = '0;
        check_states("R11");
        @(negedge clk);

        // R11: hit and bus transaction on different lines proceed together
        set_req(0, 0, 3, 0);
        set_req(2, 1, 0, 8'h66);
        #2;
        check(resp_valid == 3'b101, "R11", "parallel ack", int'(resp_valid), 3'b101);
        check(resp_rdata[7:0] == 8'h5C, "R11", "parallel rdata", int'(resp_rdata[7:0]), 8'h5C);
        model_op(2, 1, 0, 8'h66, ecmd, efrom, esrc, erd, ewb);
        @(posedge clk); #1 req_valid = '0;
        check_states("R11");
        @(negedge clk);

        // Seeded random single-cache traffic against the model
        for (int n = 0; n < 400; n++) begin
            int c = int'($urandom % NC);
            int op = int'($urandom % 4);
            int a = int'($urandom % NL);
            int wd = int'($urandom % 256);
            serve(c, op, a, wd, "RND", cmd);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog R1 act=hang exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule